// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit microcontroller core. Twelve source slots are arranged as six groups of two. Each pin is watched for an edge. A detected edge sets a flag for that source, and the flag stays set until it is cleared. A source can request only when its own enable bit and the global enable are both set. Every group has one two-bit priority level. The level is built from one bit in a low priority register and one bit in a high priority register. Level 3 is the most urgent.

The block offers the winning source to the core as a 4-bit index with a one-cycle strobe, which the core takes as its acknowledge. On that acknowledge the block clears the source's flag. The one exception is the last source: software must clear its flag. The block keeps a record of which levels are in service. A new request is granted only if its level is strictly higher than every level in service. A return strobe from the core ends the highest level in service. The last source also takes a second request, a transfer-busy event, which has its own enable and its own flag.

Top module: `irq_group_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `ack_valid` is 0 and `ack_idx` is 0. Reset clears all enable bits, the global enable, both priority registers, the polarity bits and all flags, and empties the in-service record.
- R2: Sources 0, 1, 2, 4, 6, 7 and 8 set their flag on a 0-to-1 change of the pin. A flag set at clock edge E produces `ack_valid` at edge E+1. A pin that stays high causes no further requests.
- R3: Sources 3 and 5 detect a rising edge when their polarity bit is 0 and a falling edge when it is 1. Bit 0 of `pol_wdata` controls source 3 and bit 1 controls source 5. An edge of the other direction is ignored.
- R4: The pins of sources 9 and 11 are inverted before detection, so these sources respond to a 1-to-0 change of the pin.
- R5: A source is granted only while its bit of the enable register and the global enable are both 1. A flag that is captured while the source is disabled stays pending and is granted once the source is enabled.
- R6: The level of source s is {`prio_hi` bit g, `prio_lo` bit g}, where g = s/2. Among the eligible requests, the one with the highest level wins.
- R7: Among pending requests at the same level, the lowest source index wins. This is the group order from 0 upward, with slot 0 before slot 1 inside a group.
- R8: `ack_valid` is high for exactly one cycle for each grant. For every source except 11, the grant clears that source's flag.
- R9: A grant does not clear the flag of source 11. A pulse on `ext6_clr` clears it. If the flag is still set when its level returns, the source requests again.
- R10: A rising edge on `xfer_req` sets a separate transfer flag. Source 11 then requests if `xfer_en_wdata` was written as 1 and bit 11 of the enable register is set. A pulse on `xfer_clr` clears the transfer flag.
- R11: A request is granted only if its level is strictly higher than the highest level in service. Each grant marks its level as in service. A pulse on `reti` ends the highest level in service.
- R12: Source 10 has no request input, and `ack_idx` never reports 10.
- R13: A pin level that is already present while reset is high is not treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pin | input | 12 | Request pins, one per source index |
| xfer_req | input | 1 | Transfer-busy event input |
| reti | input | 1 | Return strobe, ends the highest in-service level |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 12 | Per-source enable bits |
| ea_we | input | 1 | Write strobe for the global enable |
| ea_wdata | input | 1 | Global enable value |
| prio_lo_we | input | 1 | Write strobe for the low priority register |
| prio_lo_wdata | input | 6 | Low bit of each group's level |
| prio_hi_we | input | 1 | Write strobe for the high priority register |
| prio_hi_wdata | input | 6 | High bit of each group's level |
| pol_we | input | 1 | Write strobe for the polarity bits |
| pol_wdata | input | 2 | Falling-edge select for sources 3 and 5 |
| xfer_en_we | input | 1 | Write strobe for the transfer enable |
| xfer_en_wdata | input | 1 | Transfer enable value |
| ext6_clr | input | 1 | Software clear of the source 11 flag |
| xfer_clr | input | 1 | Software clear of the transfer flag |
| ack_valid | output | 1 | One-cycle grant strobe |
| ack_idx | output | 4 | Index of the granted source |

## Verification
Suppose the in-service record holds a wrong value. A stale entry delays a grant that should already have been made, and a missing entry lets a second grant through at the same level. Either error appears at the grant strobe within two cycles of the next request or return. Suppose instead a flag is wrong. A flag that was not cleared shows up as an extra grant right after the next return at that level. A lost flag shows up as a missing grant. Mistakes in polarity or inversion appear as a grant two cycles after the wrong pin edge. The scoreboard checks every strobe against the expected source index, in order, so an extra grant or a reordered grant is reported on the cycle it happens.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_PROG = 2'd2,
    EDGE_NONE = 2'd3
  } edge_kind_e;

  // Detection kind per source index; the last three slots follow the
  // group layout (inverted, empty, inverted + software-cleared).
  function automatic edge_kind_e src_kind(input int unsigned s, input int unsigned nsrc);
    if (s == nsrc - 2)                       return EDGE_NONE;
    else if (s == nsrc - 1 || s == nsrc - 3) return EDGE_FALL;
    else if (s == 3 || s == 5)               return EDGE_PROG;
    else                                     return EDGE_RISE;
  endfunction

  function automatic int unsigned prog_bit(input int unsigned s);
    return (s == 5) ? 1 : 0;
  endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC   = 12,
  parameter int unsigned SW_SRC = NSRC - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_pin,
  input  logic [1:0]      pol_fall,
  input  logic [NSRC-1:0] ack_clr,
  input  logic            sw_clr,
  output logic [NSRC-1:0] flag
);

  logic [NSRC-1:0] pin_q;
  logic [NSRC-1:0] hit;
  logic [NSRC-1:0] clr;

  // Previous pin level; loaded during reset so held levels are no edge.
  always_ff @(posedge clk) begin
    pin_q <= req_pin;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam edge_kind_e KIND = src_kind(s, NSRC);
    if (KIND == EDGE_NONE) begin : g_none
      assign hit[s] = 1'b0 & req_pin[s] & pin_q[s];
    end else if (KIND == EDGE_RISE) begin : g_rise
      assign hit[s] = ~rst & req_pin[s] & ~pin_q[s];
    end else if (KIND == EDGE_FALL) begin : g_fall
      assign hit[s] = ~rst & ~req_pin[s] & pin_q[s];
    end else begin : g_prog
      localparam int unsigned PB = prog_bit(s);
      assign hit[s] = ~rst & (pol_fall[PB] ? (~req_pin[s] & pin_q[s])
                                           : (req_pin[s] & ~pin_q[s]));
    end
  end

  always_comb begin
    clr = ack_clr;
    clr[SW_SRC] = sw_clr;
  end

  // A new edge wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= hit | (flag & ~clr);
  end

endmodule

// File: rtl/irq_level_select.sv
module irq_level_select #(
  parameter int unsigned NGRP  = 6,
  parameter int unsigned SLOTS = 2,
  parameter int unsigned NSRC  = NGRP * SLOTS,
  parameter int unsigned IDXW  = $clog2(NSRC),
  parameter int unsigned LVLW  = 2
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NGRP-1:0] prio_lo,
  input  logic [NGRP-1:0] prio_hi,
  input  logic            top_valid,
  input  logic [LVLW-1:0] top_lvl,
  output logic            win_valid,
  output logic [IDXW-1:0] win_idx,
  output logic [LVLW-1:0] win_lvl
);

  logic            found;
  logic [LVLW-1:0] lvl;

  // Walk downward with >= so the lowest index wins a level tie.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    lvl     = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      lvl = {prio_hi[s / SLOTS], prio_lo[s / SLOTS]};
      if (pend[s] && (!found || lvl >= win_lvl)) begin
        found   = 1'b1;
        win_idx = IDXW'(s);
        win_lvl = lvl;
      end
    end
    win_valid = found && (!top_valid || win_lvl > top_lvl);
  end

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int unsigned LVLW = 2,
  parameter int unsigned NLVL = 1 << LVLW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [LVLW-1:0] push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] ins,
  output logic            top_valid,
  output logic [LVLW-1:0] top_lvl
);

  logic [NLVL-1:0] pop_mask;
  logic [NLVL-1:0] push_mask;

  always_comb begin
    top_valid = |ins;
    top_lvl   = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (ins[l]) top_lvl = LVLW'(l);
    end
    pop_mask  = (pop && top_valid) ? (NLVL'(1) << top_lvl) : '0;
    push_mask = push ? (NLVL'(1) << push_lvl) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) ins <= '0;
    else     ins <= (ins & ~pop_mask) | push_mask;
  end

endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NGRP  = 6,
  parameter int unsigned SLOTS = 2,
  parameter int unsigned LVLW  = 2,
  parameter int unsigned NSRC  = NGRP * SLOTS,
  parameter int unsigned IDXW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_pin,
  input  logic            xfer_req,
  input  logic            reti,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            ea_we,
  input  logic            ea_wdata,
  input  logic            prio_lo_we,
  input  logic [NGRP-1:0] prio_lo_wdata,
  input  logic            prio_hi_we,
  input  logic [NGRP-1:0] prio_hi_wdata,
  input  logic            pol_we,
  input  logic [1:0]      pol_wdata,
  input  logic            xfer_en_we,
  input  logic            xfer_en_wdata,
  input  logic            ext6_clr,
  input  logic            xfer_clr,
  output logic            ack_valid,
  output logic [IDXW-1:0] ack_idx
);

  localparam int unsigned NLVL   = 1 << LVLW;
  localparam int unsigned SW_SRC = NSRC - 1;

  logic [NSRC-1:0] en_q;
  logic            ea_q;
  logic [NGRP-1:0] prio_lo_q, prio_hi_q;
  logic [1:0]      pol_q;
  logic            xfer_en_q, xfer_flag_q, xfer_pin_q;
  logic [LVLW-1:0] ack_lvl_q;

  logic [NSRC-1:0] flag_q, pend, ack_clr;
  logic [NLVL-1:0] ins_q;
  logic            top_valid, win_valid;
  logic [LVLW-1:0] top_lvl, win_lvl;
  logic [IDXW-1:0] win_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; ea_q <= 1'b0; prio_lo_q <= '0; prio_hi_q <= '0;
      pol_q <= '0; xfer_en_q <= 1'b0;
    end else begin
      if (en_we)      en_q      <= en_wdata;
      if (ea_we)      ea_q      <= ea_wdata;
      if (prio_lo_we) prio_lo_q <= prio_lo_wdata;
      if (prio_hi_we) prio_hi_q <= prio_hi_wdata;
      if (pol_we)     pol_q     <= pol_wdata;
      if (xfer_en_we) xfer_en_q <= xfer_en_wdata;
    end
  end

  // Transfer-busy event: own edge detect, own flag, software clear only.
  always_ff @(posedge clk) begin
    xfer_pin_q <= xfer_req;
    if (rst) xfer_flag_q <= 1'b0;
    else     xfer_flag_q <= (xfer_req & ~xfer_pin_q) | (xfer_flag_q & ~xfer_clr);
  end

  irq_edge_capture #(.NSRC(NSRC), .SW_SRC(SW_SRC)) u_cap (
    .clk(clk), .rst(rst), .req_pin(req_pin), .pol_fall(pol_q),
    .ack_clr(ack_clr), .sw_clr(ext6_clr), .flag(flag_q)
  );

  always_comb begin
    pend = flag_q;
    pend[SW_SRC] = flag_q[SW_SRC] | (xfer_flag_q & xfer_en_q);
    pend = pend & en_q & {NSRC{ea_q}};
  end

  irq_level_select #(
    .NGRP(NGRP), .SLOTS(SLOTS), .NSRC(NSRC), .IDXW(IDXW), .LVLW(LVLW)
  ) u_sel (
    .pend(pend), .prio_lo(prio_lo_q), .prio_hi(prio_hi_q),
    .top_valid(top_valid), .top_lvl(top_lvl),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_inservice #(.LVLW(LVLW), .NLVL(NLVL)) u_ins (
    .clk(clk), .rst(rst), .push(win_valid), .push_lvl(win_lvl), .pop(reti),
    .ins(ins_q), .top_valid(top_valid), .top_lvl(top_lvl)
  );

  always_comb begin
    ack_clr = '0;
    if (win_valid && win_idx != IDXW'(SW_SRC)) ack_clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0; ack_idx <= '0; ack_lvl_q <= '0;
    end else begin
      ack_valid <= win_valid;
      ack_idx   <= win_valid ? win_idx : '0;
      ack_lvl_q <= win_lvl;
    end
  end

endmodule

// File: rtl/irq_group_arb_chk.sv
module irq_group_arb_chk #(
  parameter int unsigned NSRC = 12,
  parameter int unsigned IDXW = 4,
  parameter int unsigned LVLW = 2,
  parameter int unsigned NLVL = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ack_valid,
  input logic [IDXW-1:0] ack_idx,
  input logic [LVLW-1:0] ack_lvl,
  input logic [NLVL-1:0] ins,
  input logic            ea,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] flag,
  input logic            sw_clr
);

  localparam int unsigned NIDX = 1 << IDXW;

  logic [NIDX-1:0] en_d;
  logic            ea_d;

  always_ff @(posedge clk) begin
    en_d <= NIDX'(en);
    ea_d <= ea;
  end

  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ea_d && en_d[ack_idx]));

  p_preempt_r11: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (($past(ins) >> ack_lvl) == '0));

  p_push_r11: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ins[ack_lvl]);

  p_no_empty_slot_r12: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ack_idx != IDXW'(NSRC - 2) && ack_idx < IDXW'(NSRC)));

  p_sw_flag_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_idx == IDXW'(NSRC - 1) && $past(flag[NSRC-1]) && !$past(sw_clr))
      |-> flag[NSRC-1]);

endmodule

bind irq_group_arb irq_group_arb_chk #(
  .NSRC(NSRC), .IDXW(IDXW), .LVLW(LVLW), .NLVL(NLVL)
) u_chk (
  .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_idx(ack_idx),
  .ack_lvl(ack_lvl_q), .ins(ins_q), .ea(ea_q), .en(en_q),
  .flag(flag_q), .sw_clr(ext6_clr)
);

// File: tb/irq_group_arb_bench.sv
module irq_group_arb_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] req_pin = 12'hA04;
  logic        xfer_req = 0, reti = 0;
  logic        en_we = 0, ea_we = 0, ea_wdata = 0;
  logic [11:0] en_wdata = '0;
  logic        prio_lo_we = 0, prio_hi_we = 0;
  logic [5:0]  prio_lo_wdata = '0, prio_hi_wdata = '0;
  logic        pol_we = 0;
  logic [1:0]  pol_wdata = '0;
  logic        xfer_en_we = 0, xfer_en_wdata = 0;
  logic        ext6_clr = 0, xfer_clr = 0;
  logic        ack_valid;
  logic [3:0]  ack_idx;

  int    errors = 0, checks = 0;
  bit    done = 0;
  string cur_tag = "R1";
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_group_arb u_irq_group_arb (
    .clk(clk), .rst(rst), .req_pin(req_pin), .xfer_req(xfer_req), .reti(reti),
    .en_we(en_we), .en_wdata(en_wdata), .ea_we(ea_we), .ea_wdata(ea_wdata),
    .prio_lo_we(prio_lo_we), .prio_lo_wdata(prio_lo_wdata),
    .prio_hi_we(prio_hi_we), .prio_hi_wdata(prio_hi_wdata),
    .pol_we(pol_we), .pol_wdata(pol_wdata),
    .xfer_en_we(xfer_en_we), .xfer_en_wdata(xfer_en_wdata),
    .ext6_clr(ext6_clr), .xfer_clr(xfer_clr),
    .ack_valid(ack_valid), .ack_idx(ack_idx)
  );

  // Monitor: every grant must match the head of the expectation queue.
  always @(negedge clk) begin
    if (!rst && ack_valid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected grant idx=%0d, expected none", cur_tag, ack_idx);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(ack_idx) != e) begin
          errors++;
          $display("FAIL %s: grant idx=%0d, expected %0d", t, ack_idx, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ack(input int idx, input string tag);
    exp_q.push_back(idx);
    tag_q.push_back(tag);
  endtask

  task automatic do_reti();
    reti = 1; cyc(1); reti = 0;
  endtask

  task automatic drain(input string tag);
    cyc(5);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d grants missing, expected 0", tag, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic wr_en(input logic [11:0] v);
    en_wdata = v; en_we = 1; cyc(1); en_we = 0;
  endtask
  task automatic wr_ea(input logic v);
    ea_wdata = v; ea_we = 1; cyc(1); ea_we = 0;
  endtask
  task automatic wr_prio(input logic [5:0] lo, input logic [5:0] hi);
    prio_lo_wdata = lo; prio_hi_wdata = hi;
    prio_lo_we = 1; prio_hi_we = 1; cyc(1); prio_lo_we = 0; prio_hi_we = 0;
  endtask
  task automatic wr_pol(input logic [1:0] v);
    pol_wdata = v; pol_we = 1; cyc(1); pol_we = 0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ack_valid=%0b, expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    cyc(3);
    check_bit(ack_valid, 1'b0, "R1");
    checks++;
    if (ack_idx !== 4'd0) begin
      errors++; $display("FAIL R1: ack_idx=%0d, expected 0", ack_idx);
    end
    rst = 0;
    cyc(1);
    check_bit(ack_valid, 1'b0, "R1");

    // R13: source 2 pin was high through reset, no grant once enabled
    cur_tag = "R13";
    wr_en(12'hFFF); wr_ea(1'b1);
    drain("R13");
    req_pin[2] = 0; cyc(2);

    // R2: rising edge, held level does not retrigger
    cur_tag = "R2";
    req_pin[0] = 1; expect_ack(0, "R2"); cyc(3); do_reti();
    cyc(6); req_pin[0] = 0;
    drain("R2");

    // R4: inverted pin, falling edge requests
    cur_tag = "R4";
    req_pin[9] = 0; expect_ack(9, "R4"); cyc(3); do_reti();
    req_pin[9] = 1;
    drain("R4");

    // R3: programmable polarity
    cur_tag = "R3";
    req_pin[3] = 1; expect_ack(3, "R3"); cyc(3); do_reti();
    req_pin[3] = 0; cyc(4);
    wr_pol(2'b01);
    req_pin[3] = 1; cyc(4);
    req_pin[3] = 0; expect_ack(3, "R3"); cyc(3); do_reti();
    wr_pol(2'b10);
    req_pin[5] = 1; cyc(4);
    req_pin[5] = 0; expect_ack(5, "R3"); cyc(3); do_reti();
    wr_pol(2'b00);
    drain("R3");

    // R12: empty slot never requests
    cur_tag = "R12";
    req_pin[10] = 1; cyc(3); req_pin[10] = 0;
    drain("R12");

    // R6: level from the two priority registers
    cur_tag = "R6";
    wr_prio(6'b000100, 6'b001000);   // group 2 -> level 1, group 3 -> level 2
    req_pin[1] = 1; req_pin[6] = 1; req_pin[4] = 1;
    expect_ack(6, "R6"); expect_ack(4, "R6"); expect_ack(1, "R6");
    cyc(3); do_reti(); cyc(3); do_reti(); cyc(3); do_reti();
    req_pin[1] = 0; req_pin[6] = 0; req_pin[4] = 0;
    drain("R6");

    // R11: preemption only by a strictly higher level
    cur_tag = "R11";
    req_pin[1] = 1; expect_ack(1, "R11"); cyc(3);
    req_pin[6] = 1; expect_ack(6, "R11"); cyc(3);
    req_pin[0] = 1; req_pin[7] = 1; cyc(5);
    expect_ack(7, "R11"); do_reti(); cyc(3);
    do_reti(); cyc(5);
    expect_ack(0, "R11"); do_reti(); cyc(3);
    do_reti();
    req_pin[0] = 0; req_pin[1] = 0; req_pin[6] = 0; req_pin[7] = 0;
    drain("R11");
    wr_prio(6'b0, 6'b0);

    // R7: same-level polling order
    cur_tag = "R7";
    req_pin[5] = 1; req_pin[4] = 1; req_pin[1] = 1;
    expect_ack(1, "R7"); expect_ack(4, "R7"); expect_ack(5, "R7");
    cyc(3); do_reti(); cyc(3); do_reti(); cyc(3); do_reti();
    req_pin[5] = 0; req_pin[4] = 0; req_pin[1] = 0;
    drain("R7");

    // R5: enable gating keeps the flag pending
    cur_tag = "R5";
    wr_en(12'hEFF);
    req_pin[8] = 1; cyc(6);
    drain("R5");
    expect_ack(8, "R5"); wr_en(12'hFFF); cyc(3); do_reti();
    req_pin[8] = 0;
    wr_ea(1'b0);
    req_pin[0] = 1; cyc(5);
    expect_ack(0, "R5"); wr_ea(1'b1); cyc(3); do_reti();
    req_pin[0] = 0;
    drain("R5");

    // R8: one-cycle strobe, flag cleared by the grant
    cur_tag = "R8";
    req_pin[6] = 1; expect_ack(6, "R8"); cyc(2);
    check_bit(ack_valid, 1'b1, "R8");
    cyc(1);
    check_bit(ack_valid, 1'b0, "R8");
    do_reti(); cyc(6);
    req_pin[6] = 0;
    drain("R8");

    // R9: source 11 flag needs the software clear
    cur_tag = "R9";
    req_pin[11] = 0; expect_ack(11, "R9"); cyc(3);
    expect_ack(11, "R9"); do_reti(); cyc(3);
    ext6_clr = 1; cyc(1); ext6_clr = 0;
    do_reti(); cyc(4);
    req_pin[11] = 1;
    drain("R9");

    // R10: transfer-busy event with its own enable and clear
    cur_tag = "R10";
    xfer_en_wdata = 1; xfer_en_we = 1; cyc(1); xfer_en_we = 0;
    xfer_req = 1; expect_ack(11, "R10"); cyc(3);
    xfer_clr = 1; cyc(1); xfer_clr = 0;
    do_reti(); xfer_req = 0;
    drain("R10");
    xfer_en_wdata = 0; xfer_en_we = 1; cyc(1); xfer_en_we = 0;
    xfer_req = 1; cyc(5); xfer_req = 0;
    xfer_clr = 1; cyc(1); xfer_clr = 0;
    drain("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule